// File: doc/BRIEF.md
# Valley Target Selector

This block decides at which ring valley, counted from 1 to 7, the power switch of a quasi-resonant flyback converter may turn on once the transformer has demagnetized. A high valley number stretches the off-time and lowers the switching frequency. That suits light load. A low number keeps the frequency high for heavy load. The block watches three digital comparator flags that report where the feedback level sits against a lower count threshold, an upper count threshold and a fast-reset threshold. It gathers what happened over a long evaluation window. When the window closes, it steps the valley target up, holds it or steps it down.

A feedback excursion above the reset threshold snaps the target back to 1 at once, so the converter can react quickly to a sudden load step. A pulse that marks the end of burst operation does the same. Both events also start a fresh window. The analog comparators work on one of two threshold pairs, one for low line and one for high line. The block chooses the pair with a hysteretic flag that it drives from two line-current flags. The window length is given in clock cycles. At a 50 MHz clock the default of 2,400,000 cycles gives a 48 ms window.

Top module: `valley_target_sel`

## Requirements
- R1: While reset is asserted and right after it, `valley_o` is 1 and `high_line_o` is 0 (the low-line threshold pair is selected).
- R2: If `fb_above_low_i` is never high in a window of `WIN_CYCLES` clock edges, `valley_o` increases by one on the last edge of that window and stays unchanged on all earlier edges.
- R3: If `fb_above_low_i` is high in at least one cycle of a window but `fb_above_high_i` never is, `valley_o` is unchanged at the window end.
- R4: If `fb_above_high_i` is high in at least one cycle of a window and `fb_above_reset_i` never is, `valley_o` decreases by one at the window end.
- R5: `valley_o` saturates: an increase at 7 leaves it at 7, and a decrease at 1 leaves it at 1.
- R6: A cycle with `fb_above_reset_i` high sets `valley_o` to 1 on the next clock edge. This takes priority over any window action. A new window of `WIN_CYCLES` edges starts after that edge.
- R7: A cycle with `burst_exit_i` high sets `valley_o` to 1 on the next clock edge and starts a new window in the same way.
- R8: `high_line_o` becomes 1 on the edge after `line_above_hi_i` is high. It becomes 0 on the edge after `line_below_lo_i` is high while `line_above_hi_i` is low. It holds when neither flag is high. `high_line_o` = 1 selects the high-line threshold pair.
- R9: `valley_o` never leaves the range 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, used at start-up |
| fb_above_low_i | input | 1 | Feedback above the lower count threshold |
| fb_above_high_i | input | 1 | Feedback above the upper count threshold |
| fb_above_reset_i | input | 1 | Feedback above the fast-reset threshold |
| line_above_hi_i | input | 1 | Line-sense current above the upper line limit |
| line_below_lo_i | input | 1 | Line-sense current below the lower line limit |
| burst_exit_i | input | 1 | One-cycle pulse when burst operation ends |
| high_line_o | output | 1 | Threshold pair select: 1 high-line, 0 low-line |
| valley_o | output | 3 | Valley target, 1 to 7 |

## Verification
If the window counter drifts, the target moves a cycle early or late. The bench sees this on the edge it checks, because it samples one cycle before each window end as well as after it. If a sticky flag is lost or never cleared, the step at the next window close goes the wrong way, so a single window exposes the fault. If the reset path or the burst-exit path is broken, the target does not read 1 one edge after the event. If the window does not restart on these events, the next step lands several cycles early. A swapped hysteresis branch shows on `high_line_o` one edge after the line flags change.

// File: rtl/vts_pkg.sv
package vts_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2,
        ACT_ONE  = 2'd3
    } vts_act_e;

    // Priority: forced reload, then window-end decision, otherwise hold.
    function automatic vts_act_e decide(input logic force_one,
                                        input logic win_end,
                                        input logic seen_low,
                                        input logic seen_high);
        vts_act_e act;
        if (force_one)       act = ACT_ONE;
        else if (!win_end)   act = ACT_HOLD;
        else if (seen_high)  act = ACT_DOWN;
        else if (seen_low)   act = ACT_HOLD;
        else                 act = ACT_UP;
        return act;
    endfunction

endpackage

// File: rtl/vts_line_hyst.sv
module vts_line_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi_i,
    input  logic below_lo_i,
    output logic high_line_o
);
    typedef struct packed {
        logic high_line;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (above_hi_i)      st_d.high_line = 1'b1;
        else if (below_lo_i) st_d.high_line = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign high_line_o = st_q.high_line;

    // R8: upper line flag selects the high-line pair next cycle
    a_r8_line_set: assert property (@(posedge clk) disable iff (!rst_n)
        above_hi_i |=> high_line_o);
    // R8: lower line flag alone returns to the low-line pair
    a_r8_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (below_lo_i && !above_hi_i) |=> !high_line_o);
    // R8: no flag, no change
    a_r8_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!below_lo_i && !above_hi_i) |=> $stable(high_line_o));
endmodule

// File: rtl/vts_window.sv
module vts_window #(
    parameter int WIN_CYCLES = 2400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic fb_low_i,
    input  logic fb_high_i,
    output logic win_end_o,
    output logic seen_low_o,
    output logic seen_high_o
);
    localparam int CNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             low_seen;
        logic             high_seen;
    } st_t;

    st_t  st_d, st_q;
    logic at_last;

    assign at_last     = (st_q.cnt == LAST);
    // The current sample belongs to the window, so fold it in directly.
    assign seen_low_o  = st_q.low_seen  | fb_low_i;
    assign seen_high_o = st_q.high_seen | fb_high_i;
    assign win_end_o   = at_last;

    always_comb begin
        st_d = st_q;
        if (restart_i || at_last) begin
            st_d.cnt       = '0;
            st_d.low_seen  = 1'b0;
            st_d.high_seen = 1'b0;
        end else begin
            st_d.cnt       = st_q.cnt + 1'b1;
            st_d.low_seen  = seen_low_o;
            st_d.high_seen = seen_high_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6 / R7: a restart empties the window state
    a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.cnt == '0 && !st_q.low_seen && !st_q.high_seen));
    // R2: the window wraps after its last cycle
    a_r2_window_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_o |=> (st_q.cnt == '0));
endmodule

// File: rtl/vts_valley_reg.sv
module vts_valley_reg
    import vts_pkg::*;
#(
    parameter int VAL_W   = 3,
    parameter int VAL_MIN = 1,
    parameter int VAL_MAX = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_one_i,
    input  logic             win_end_i,
    input  logic             seen_low_i,
    input  logic             seen_high_i,
    output logic [VAL_W-1:0] valley_o
);
    localparam logic [VAL_W-1:0] VMIN = VAL_W'(VAL_MIN);
    localparam logic [VAL_W-1:0] VMAX = VAL_W'(VAL_MAX);

    typedef struct packed {
        logic [VAL_W-1:0] val;
    } st_t;

    st_t      st_d, st_q;
    vts_act_e act;

    always_comb begin
        act  = decide(force_one_i, win_end_i, seen_low_i, seen_high_i);
        st_d = st_q;
        case (act)
            ACT_ONE:  st_d.val = VMIN;
            ACT_UP:   if (st_q.val < VMAX) st_d.val = st_q.val + 1'b1;
            ACT_DOWN: if (st_q.val > VMIN) st_d.val = st_q.val - 1'b1;
            default:  st_d.val = st_q.val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.val <= VMIN;
        else        st_q     <= st_d;
    end

    assign valley_o = st_q.val;

    // R9: target stays in range
    a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
        (valley_o >= VMIN) && (valley_o <= VMAX));
    // R5: at most one step per edge unless reloaded to the minimum
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(valley_o) |-> (valley_o == VMIN ||
                                valley_o == $past(valley_o) + 1'b1 ||
                                valley_o == $past(valley_o) - 1'b1));
endmodule

// File: rtl/valley_target_sel.sv
module valley_target_sel #(
    parameter int WIN_CYCLES = 2400000,
    parameter int VAL_W      = 3,
    parameter int VAL_MIN    = 1,
    parameter int VAL_MAX    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fb_above_low_i,
    input  logic             fb_above_high_i,
    input  logic             fb_above_reset_i,
    input  logic             line_above_hi_i,
    input  logic             line_below_lo_i,
    input  logic             burst_exit_i,
    output logic             high_line_o,
    output logic [VAL_W-1:0] valley_o
);
    logic force_one;
    logic win_end;
    logic seen_low;
    logic seen_high;

    assign force_one = fb_above_reset_i | burst_exit_i;

    vts_line_hyst u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .above_hi_i  (line_above_hi_i),
        .below_lo_i  (line_below_lo_i),
        .high_line_o (high_line_o)
    );

    vts_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (force_one),
        .fb_low_i    (fb_above_low_i),
        .fb_high_i   (fb_above_high_i),
        .win_end_o   (win_end),
        .seen_low_o  (seen_low),
        .seen_high_o (seen_high)
    );

    vts_valley_reg #(.VAL_W(VAL_W), .VAL_MIN(VAL_MIN), .VAL_MAX(VAL_MAX)) u_val (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_one_i (force_one),
        .win_end_i   (win_end),
        .seen_low_i  (seen_low),
        .seen_high_i (seen_high),
        .valley_o    (valley_o)
    );

    // R6: fast-reset threshold forces the minimum next edge
    a_r6_reset_to_min: assert property (@(posedge clk) disable iff (!rst_n)
        fb_above_reset_i |=> (valley_o == VAL_W'(VAL_MIN)));
    // R7: leaving burst forces the minimum next edge
    a_r7_burst_exit_min: assert property (@(posedge clk) disable iff (!rst_n)
        burst_exit_i |=> (valley_o == VAL_W'(VAL_MIN)));
    // R2: target moves only at a window end or on a forced reload
    a_r2_change_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_end || force_one) |=> $stable(valley_o));
    // R3: dead band holds the target
    a_r3_dead_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && seen_low && !seen_high && !force_one) |=> $stable(valley_o));
endmodule

// File: tb/test_valley_target_sel.sv
module test_valley_target_sel;
    localparam int WIN = 8;

    typedef struct packed {
        logic       lo;
        logic       hi;
        logic       rst;
        logic       pulse;
        logic [2:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd2},  // R2
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd4},
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd5},
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd6},
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd7},
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd7},  // R5 top
        '{1'b1, 1'b0, 1'b0, 1'b1, 3'd7},  // R3 pulse
        '{1'b1, 1'b0, 1'b0, 1'b0, 3'd7},  // R3 held
        '{1'b1, 1'b1, 1'b0, 1'b1, 3'd6},  // R4 pulse
        '{1'b1, 1'b1, 1'b0, 1'b0, 3'd5},  // R4 held
        '{1'b1, 1'b1, 1'b0, 1'b0, 3'd4},
        '{1'b1, 1'b1, 1'b0, 1'b0, 3'd3},
        '{1'b1, 1'b1, 1'b0, 1'b0, 3'd2},
        '{1'b1, 1'b1, 1'b0, 1'b0, 3'd1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 3'd1},  // R5 bottom
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd2},
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
        '{1'b1, 1'b1, 1'b1, 1'b0, 3'd1},  // R6 priority
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd2},
        '{1'b1, 1'b0, 1'b0, 1'b1, 3'd2}   // R3 at low value
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fb_lo = 1'b0, fb_hi = 1'b0, fb_rst = 1'b0;
    logic       ln_hi = 1'b0, ln_lo = 1'b0, bexit = 1'b0;
    logic       high_line;
    logic [2:0] valley;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    valley_target_sel #(.WIN_CYCLES(WIN)) i_valley_target_sel (
        .clk              (clk),
        .rst_n            (rst_n),
        .fb_above_low_i   (fb_lo),
        .fb_above_high_i  (fb_hi),
        .fb_above_reset_i (fb_rst),
        .line_above_hi_i  (ln_hi),
        .line_below_lo_i  (ln_lo),
        .burst_exit_i     (bexit),
        .high_line_o      (high_line),
        .valley_o         (valley)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic zeros(input int n);
        fb_lo = 1'b0; fb_hi = 1'b0;
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        int prev;
        @(negedge clk);
        chk("R1 valley in reset", valley, 1);
        chk("R1 line in reset", high_line, 0);
        cyc();
        rst_n = 1'b1;
        chk("R1 valley after reset", valley, 1);

        prev = 1;
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].rst) begin
                fb_lo = VECS[v].lo; fb_hi = VECS[v].hi; fb_rst = 1'b1;
                cyc();
                fb_rst = 1'b0; fb_lo = 1'b0; fb_hi = 1'b0;
                chk("R6 table reset", valley, VECS[v].exp);
            end else begin
                for (int c = 0; c < WIN; c++) begin
                    if (VECS[v].pulse) begin
                        fb_lo = (c == 3) ? VECS[v].lo : 1'b0;
                        fb_hi = (c == 3) ? VECS[v].hi : 1'b0;
                    end else begin
                        fb_lo = VECS[v].lo;
                        fb_hi = VECS[v].hi;
                    end
                    if (c == WIN - 1) chk("R2 no early step", valley, prev);
                    cyc();
                end
                fb_lo = 1'b0; fb_hi = 1'b0;
                chk("R2/R3/R4/R5 window end", valley, VECS[v].exp);
            end
            prev = VECS[v].exp;
        end

        // R6: reset threshold mid-window restarts the window (valley now 2)
        zeros(3);
        fb_rst = 1'b1; cyc(); fb_rst = 1'b0;
        chk("R6 mid-window reload", valley, 1);
        zeros(WIN - 1);
        chk("R6 window restarted", valley, 1);
        zeros(1);
        chk("R6 step after restart", valley, 2);

        // R7: burst exit reload and restart
        zeros(2);
        bexit = 1'b1; cyc(); bexit = 1'b0;
        chk("R7 burst exit reload", valley, 1);
        zeros(WIN - 1);
        chk("R7 window restarted", valley, 1);
        zeros(1);
        chk("R7 step after restart", valley, 2);

        // R8: line hysteresis
        chk("R8 low-line default", high_line, 0);
        ln_hi = 1'b1; cyc(); ln_hi = 1'b0;
        chk("R8 switch to high-line", high_line, 1);
        cyc(); cyc();
        chk("R8 hold high-line", high_line, 1);
        ln_lo = 1'b1; cyc(); ln_lo = 1'b0;
        chk("R8 return to low-line", high_line, 0);
        cyc();
        chk("R8 hold low-line", high_line, 0);
        ln_hi = 1'b1; ln_lo = 1'b1; cyc(); ln_hi = 1'b0; ln_lo = 1'b0;
        chk("R8 upper flag wins", high_line, 1);

        // R1 / R9: reset during operation, value back to 1
        zeros(WIN);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset valley", valley, 1);
        chk("R1 async reset line", high_line, 0);
        cyc();
        rst_n = 1'b1;
        zeros(WIN);
        chk("R9 range after restart", valley, 2);

        done = 1'b1;
        report();
    end
endmodule